// File: doc/BRIEF.md
# Triple-Redundant Handshake Functional Monitor

This block sits on the test side of a triplicated device under test. It keeps a continuous request/response handshake with all three redundancy domains. Each domain gets its own copy of the clock, the reset, a 16-bit stimulus bus with its valid strobe, and an exception acknowledge. The stimulus words come from a small computed table. The three returned result buses, result-valid strobes and exception strobes pass through two-of-three majority voters. After voting, every answer is sorted into one of three fault classes, and each class has its own saturating counter.

The controller has three states. `ST_DUT_RST` holds all three domain resets high for a fixed number of cycles. `ST_ISSUE` presents the current vector and waits for a voted response. `ST_GAP` drops the valid strobes for one cycle after a response is consumed, and raises the exception acknowledge in that cycle if an exception was seen. The transitions are:
- `ST_DUT_RST`→`ST_ISSUE` when the reset hold ends.
- `ST_ISSUE`→`ST_GAP` on a voted response or exception.
- `ST_ISSUE`→`ST_DUT_RST` on timeout.
- `ST_GAP`→`ST_ISSUE` unconditionally.

A timeout is counted as a sequence fault. It also restarts the vector table from its first entry.

Top module: `tmr_func_monitor`

## Requirements
- R1: After `rst_n` is released, all three `dut_rst_o` lines are high for exactly RST_CYC clock cycles. Then all three `vec_vld_o` lines rise. All three counters read zero out of reset.
- R2: Vector number k is (k·0x1357 + 0x00A5) mod 2^16, with k counting from 0. It appears identically on the three data buses while `vec_vld_o` is 3'b111. Each consumed response or exception advances k, and k wraps to 0 after NUM_VEC−1.
- R3: A response, an exception or a result bit is taken only when at least two domains agree. A single domain that differs in valid, exception or data has no effect.
- R4: A voted result-valid whose voted data differs from {v[7:0],v[15:8]} XOR 0x5A5A (v being the current vector) increments `err_result_cnt` at the consuming clock edge. A matching result leaves it unchanged.
- R5: If no voted result-valid or exception arrives within `timeout_limit` cycles of `ST_ISSUE`, `err_timeout_cnt` increments and the monitor re-enters `ST_DUT_RST`. The restart runs the full RST_CYC reset hold, then issues vector 0.
- R6: A voted response that arrives in the last cycle of the timeout window is consumed normally, and no timeout is counted.
- R7: A `timeout_limit` of 0 disables the timeout, so the monitor waits indefinitely.
- R8: A voted exception increments `err_exc_cnt` and consumes the vector. `exc_ack_o` is 3'b111 for exactly the following single cycle.
- R9: After every consumed response, `vec_vld_o` is 3'b000 for exactly one cycle before the next vector is issued.
- R10: Each counter stops at 2^CNT_W−1 and never wraps.
- R11: `clr_counts` zeroes all three counters at the next edge, and it wins over a coincident increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low monitor reset |
| clr_counts | input | 1 | Synchronous clear of the three fault counters |
| timeout_limit | input | TO_W | Response window in cycles; 0 disables |
| dut_clk_o | output | 3 | Per-domain clock copies |
| dut_rst_o | output | 3 | Per-domain reset, active high |
| vec_vld_o | output | 3 | Per-domain stimulus valid |
| vec_data_o | output | 3×16 | Per-domain stimulus word |
| exc_ack_o | output | 3 | Per-domain exception acknowledge |
| res_data_i | input | 3×16 | Per-domain result word |
| res_vld_i | input | 3 | Per-domain result valid |
| exc_vld_i | input | 3 | Per-domain exception strobe |
| err_result_cnt | output | CNT_W | Wrong-result fault count |
| err_timeout_cnt | output | CNT_W | Sequence/timeout fault count |
| err_exc_cnt | output | CNT_W | Exception event count |

## Verification
Two pairs of functions can collide in a single cycle.

The first pair is the arrival of a voted response and the expiry of the timeout. The bench withholds the answer until the final cycle of a five-cycle window, then answers once correctly and once with a wrong word. It expects no timeout and no domain reset, and expects the wrong word to be counted only as a result fault.

The second pair is a counter clear and a fault increment. The bench raises `clr_counts` in the same cycle that a wrong result is consumed, and requires all three counters to read zero afterwards.

// File: rtl/tmr_mon_pkg.sv
package tmr_mon_pkg;

    localparam int DW = 16;

    typedef enum logic [1:0] {
        ST_DUT_RST = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_GAP     = 2'd2
    } mon_state_e;

    // Stimulus word for table position k.
    function automatic logic [DW-1:0] vec_of(input logic [DW-1:0] k);
        return k * 16'h1357 + 16'h00A5;
    endfunction

    // Result a healthy device returns for stimulus v.
    function automatic logic [DW-1:0] expect_of(input logic [DW-1:0] v);
        return {v[7:0], v[15:8]} ^ 16'h5A5A;
    endfunction

endpackage

// File: rtl/maj_vote.sv
module maj_vote #(
    parameter int W = 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    always_comb y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && (cnt != {W{1'b1}}))
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/tmr_func_monitor.sv
module tmr_func_monitor
    import tmr_mon_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int TO_W    = 16,
    parameter int CNT_W   = 8,
    parameter int RST_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_counts,
    input  logic [TO_W-1:0]      timeout_limit,
    output logic [2:0]           dut_clk_o,
    output logic [2:0]           dut_rst_o,
    output logic [2:0]           vec_vld_o,
    output logic [2:0][DW-1:0]   vec_data_o,
    output logic [2:0]           exc_ack_o,
    input  logic [2:0][DW-1:0]   res_data_i,
    input  logic [2:0]           res_vld_i,
    input  logic [2:0]           exc_vld_i,
    output logic [CNT_W-1:0]     err_result_cnt,
    output logic [CNT_W-1:0]     err_timeout_cnt,
    output logic [CNT_W-1:0]     err_exc_cnt
);

    localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
    localparam int RC_W  = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_VEC - 1);
    localparam logic [RC_W-1:0]  RC_LAST  = RC_W'(RST_CYC - 1);

    mon_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [TO_W-1:0]  timer_q;
    logic [RC_W-1:0]  rcnt_q;
    logic             exc_seen_q;

    logic [DW-1:0]    voted_data;
    logic [1:0]       voted_ctl;
    logic             v_vld, v_exc, rsp, expired;
    logic [DW-1:0]    cur_vec, cur_exp;
    logic [2:0]       inc_vec;
    logic [2:0][CNT_W-1:0] cnt_arr;

    // ---- voting of the three returned domains ----
    maj_vote #(.W(DW)) u_vote_data (
        .a(res_data_i[0]), .b(res_data_i[1]), .c(res_data_i[2]), .y(voted_data)
    );
    maj_vote #(.W(2)) u_vote_ctl (
        .a({res_vld_i[0], exc_vld_i[0]}),
        .b({res_vld_i[1], exc_vld_i[1]}),
        .c({res_vld_i[2], exc_vld_i[2]}),
        .y(voted_ctl)
    );
    assign v_vld = voted_ctl[1];
    assign v_exc = voted_ctl[0];

    assign cur_vec = vec_of(DW'(idx_q));
    assign cur_exp = expect_of(cur_vec);
    assign rsp     = (state_q == ST_ISSUE) && (v_vld || v_exc);
    assign expired = (state_q == ST_ISSUE) && !(v_vld || v_exc)
                   && (timeout_limit != '0)
                   && (timer_q == timeout_limit - TO_W'(1));

    // ---- fault classification ----
    assign inc_vec[0] = rsp && v_vld && (voted_data != cur_exp);
    assign inc_vec[1] = expired;
    assign inc_vec[2] = rsp && v_exc;

    for (genvar g = 0; g < 3; g++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr_counts),
            .inc(inc_vec[g]), .cnt(cnt_arr[g])
        );
    end
    assign err_result_cnt  = cnt_arr[0];
    assign err_timeout_cnt = cnt_arr[1];
    assign err_exc_cnt     = cnt_arr[2];

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DUT_RST;
        else        state_q <= state_d;
    end

    // ---- next state ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DUT_RST: if (rcnt_q == RC_LAST) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (rsp)          state_d = ST_GAP;
                else if (expired) state_d = ST_DUT_RST;
            end
            ST_GAP:               state_d = ST_ISSUE;
            default:              state_d = ST_DUT_RST;
        endcase
    end

    // ---- sequencing registers ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            timer_q    <= '0;
            rcnt_q     <= '0;
            exc_seen_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DUT_RST: begin
                    rcnt_q  <= (rcnt_q == RC_LAST) ? '0 : rcnt_q + RC_W'(1);
                    timer_q <= '0;
                    idx_q   <= '0;
                end
                ST_ISSUE: begin
                    if (rsp) begin
                        idx_q      <= (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
                        timer_q    <= '0;
                        exc_seen_q <= v_exc;
                    end else if (expired) begin
                        timer_q <= '0;
                    end else begin
                        timer_q <= timer_q + TO_W'(1);
                    end
                end
                ST_GAP:  exc_seen_q <= 1'b0;
                default: rcnt_q     <= '0;
            endcase
        end
    end

    // ---- outputs ----
    always_comb begin
        dut_clk_o  = {3{clk}};
        dut_rst_o  = 3'b000;
        vec_vld_o  = 3'b000;
        exc_ack_o  = 3'b000;
        vec_data_o = {3{cur_vec}};
        unique case (state_q)
            ST_DUT_RST: dut_rst_o = 3'b111;
            ST_ISSUE:   vec_vld_o = 3'b111;
            ST_GAP:     exc_ack_o = exc_seen_q ? 3'b111 : 3'b000;
            default:    dut_rst_o = 3'b111;
        endcase
    end

endmodule

// File: rtl/tmr_func_monitor_chk.sv
module tmr_func_monitor_chk #(
    parameter int CNT_W   = 8,
    parameter int RST_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_counts,
    input logic [2:0]       dut_rst_o,
    input logic [2:0]       vec_vld_o,
    input logic [2:0]       exc_ack_o,
    input logic [CNT_W-1:0] err_result_cnt,
    input logic [CNT_W-1:0] err_timeout_cnt,
    input logic [CNT_W-1:0] err_exc_cnt
);
    int rst_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            rst_run <= 0;
        else if (dut_rst_o[0]) rst_run <= rst_run + 1;
        else                   rst_run <= 0;
    end

    p_rst_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!dut_rst_o[0] && $past(dut_rst_o[0])) |-> (rst_run == RST_CYC));

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dut_rst_o[0], vec_vld_o[0], exc_ack_o[0]}));

    p_to_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout_cnt > $past(err_timeout_cnt)) |-> (dut_rst_o == 3'b111));

    p_ack_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ack_o == 3'b111) |=> (exc_ack_o == 3'b000));

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_counts |=> (err_result_cnt >= $past(err_result_cnt))
                     && (err_timeout_cnt >= $past(err_timeout_cnt))
                     && (err_exc_cnt >= $past(err_exc_cnt)));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_counts |=> (CNT_W'(err_result_cnt - $past(err_result_cnt)) <= CNT_W'(1)));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_counts |=> (err_result_cnt == '0) && (err_timeout_cnt == '0)
                    && (err_exc_cnt == '0));
endmodule

bind tmr_func_monitor tmr_func_monitor_chk #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_counts(clr_counts),
    .dut_rst_o(dut_rst_o), .vec_vld_o(vec_vld_o), .exc_ack_o(exc_ack_o),
    .err_result_cnt(err_result_cnt), .err_timeout_cnt(err_timeout_cnt),
    .err_exc_cnt(err_exc_cnt)
);

// File: tb/tmr_func_monitor_bench.sv
`timescale 1ns/1ps
module tmr_func_monitor_bench;
    localparam int NV = 8;
    localparam int RC = 4;
    localparam int CW = 4;
    localparam int TW = 16;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic clk = 1'b0, rst_n = 1'b0, clr_counts = 1'b0;
    logic [TW-1:0] timeout_limit = 16'd100;
    logic [2:0] dut_clk_o, dut_rst_o, vec_vld_o, exc_ack_o;
    logic [2:0][15:0] vec_data_o;
    logic [2:0][15:0] res_data_i = '0;
    logic [2:0] res_vld_i = 3'b000, exc_vld_i = 3'b000;
    logic [CW-1:0] err_result_cnt, err_timeout_cnt, err_exc_cnt;

    int n_chk = 0, n_bad = 0, mi = 0;
    int e1 = 0, e2 = 0, e3 = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tmr_func_monitor #(.NUM_VEC(NV), .TO_W(TW), .CNT_W(CW), .RST_CYC(RC)) u_tmr_func_monitor (
        .clk(clk), .rst_n(rst_n), .clr_counts(clr_counts), .timeout_limit(timeout_limit),
        .dut_clk_o(dut_clk_o), .dut_rst_o(dut_rst_o), .vec_vld_o(vec_vld_o),
        .vec_data_o(vec_data_o), .exc_ack_o(exc_ack_o),
        .res_data_i(res_data_i), .res_vld_i(res_vld_i), .exc_vld_i(exc_vld_i),
        .err_result_cnt(err_result_cnt), .err_timeout_cnt(err_timeout_cnt),
        .err_exc_cnt(err_exc_cnt)
    );

    function automatic logic [15:0] vec_m(input int k);
        logic [31:0] t = k * 32'h1357 + 32'h00A5;
        return t[15:0];
    endfunction
    function automatic logic [15:0] good_m(input int k);
        logic [15:0] v = vec_m(k);
        return {v[7:0], v[15:8]} ^ 16'h5A5A;
    endfunction
    function automatic int sat(input int x);
        return (x > int'(CMAX)) ? int'(CMAX) : x;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_counts(input string req);
        chk(err_result_cnt == CW'(e1), req, 32'(err_result_cnt), 32'(e1));
        chk(err_timeout_cnt == CW'(e2), req, 32'(err_timeout_cnt), 32'(e2));
        chk(err_exc_cnt == CW'(e3), req, 32'(err_exc_cnt), 32'(e3));
    endtask

    task automatic wait_issue();
        int k = 0;
        while (vec_vld_o != 3'b111 && k < 1000) begin @(negedge clk); k++; end
        chk(vec_vld_o == 3'b111, "R2 vector issued", 32'(vec_vld_o), 32'h7);
    endtask

    task automatic respond(input logic [15:0] d0, input logic [15:0] d1, input logic [15:0] d2,
                           input logic [2:0] v, input logic [2:0] x);
        res_data_i[0] = d0; res_data_i[1] = d1; res_data_i[2] = d2;
        res_vld_i = v; exc_vld_i = x;
        @(posedge clk);
        @(negedge clk);
        res_vld_i = 3'b000; exc_vld_i = 3'b000; res_data_i = '0;
    endtask

    task automatic t_reset();
        int k = 0;
        @(negedge clk);
        chk(dut_rst_o == 3'b111, "R1 reset held in reset", 32'(dut_rst_o), 32'h7);
        chk_counts("R1 counters zero");
        rst_n = 1'b1;
        while (dut_rst_o == 3'b111 && k < 100) begin @(negedge clk); k++; end
        chk(k == RC, "R1 reset length", 32'(k), 32'(RC));
        chk(vec_vld_o == 3'b111, "R1 valid after reset", 32'(vec_vld_o), 32'h7);
        mi = 0;
    endtask

    task automatic t_good_run();
        for (int n = 0; n < NV + 3; n++) begin
            wait_issue();
            for (int d = 0; d < 3; d++)
                chk(vec_data_o[d] == vec_m(mi), "R2 vector word", 32'(vec_data_o[d]), 32'(vec_m(mi)));
            respond(good_m(mi), good_m(mi), good_m(mi), 3'b111, 3'b000);
            mi = (mi + 1) % NV;
            chk(vec_vld_o == 3'b000, "R9 gap cycle", 32'(vec_vld_o), 0);
            chk_counts("R4 correct result not counted");
            @(negedge clk);
            chk(vec_vld_o == 3'b111, "R9 gap is one cycle", 32'(vec_vld_o), 32'h7);
        end
    endtask

    task automatic t_minority();
        wait_issue();
        res_data_i[0] = good_m(mi); res_vld_i = 3'b001;
        @(posedge clk); @(negedge clk);
        res_vld_i = 3'b000; res_data_i = '0;
        chk(vec_vld_o == 3'b111, "R3 lone valid ignored", 32'(vec_vld_o), 32'h7);
        exc_vld_i = 3'b100;
        @(posedge clk); @(negedge clk);
        exc_vld_i = 3'b000;
        chk(vec_vld_o == 3'b111, "R3 lone exception ignored", 32'(vec_vld_o), 32'h7);
        chk_counts("R3 lone strobes not counted");
        respond(good_m(mi), good_m(mi), ~good_m(mi), 3'b111, 3'b000);
        mi = (mi + 1) % NV;
        chk_counts("R3 one bad data copy outvoted");
        wait_issue();
        respond(~good_m(mi), good_m(mi), ~good_m(mi), 3'b111, 3'b000);
        mi = (mi + 1) % NV; e1 = sat(e1 + 1);
        chk_counts("R3 two bad copies win vote");
    endtask

    task automatic t_wrong();
        wait_issue();
        respond(16'h1234, 16'h1234, 16'h1234, 3'b110, 3'b000);
        mi = (mi + 1) % NV; e1 = sat(e1 + 1);
        chk_counts("R4 wrong result counted");
    endtask

    task automatic t_exception();
        wait_issue();
        respond('0, '0, '0, 3'b000, 3'b011);
        mi = (mi + 1) % NV; e3 = sat(e3 + 1);
        chk_counts("R8 exception counted");
        chk(exc_ack_o == 3'b111, "R8 acknowledge raised", 32'(exc_ack_o), 32'h7);
        @(negedge clk);
        chk(exc_ack_o == 3'b000, "R8 acknowledge one cycle", 32'(exc_ack_o), 0);
        chk(vec_data_o[1] == vec_m(mi), "R8 vector consumed", 32'(vec_data_o[1]), 32'(vec_m(mi)));
    endtask

    task automatic t_timeout();
        int k = 0;
        timeout_limit = 16'd5;
        wait_issue();
        repeat (4) @(negedge clk);
        chk(vec_vld_o == 3'b111, "R5 still waiting", 32'(vec_vld_o), 32'h7);
        chk_counts("R5 no early timeout");
        @(negedge clk);
        e2 = sat(e2 + 1);
        chk(dut_rst_o == 3'b111, "R5 domains reset", 32'(dut_rst_o), 32'h7);
        chk_counts("R5 timeout counted");
        while (dut_rst_o == 3'b111 && k < 100) begin @(negedge clk); k++; end
        chk(k == RC, "R5 restart reset length", 32'(k), 32'(RC));
        mi = 0;
        chk(vec_data_o[2] == vec_m(0), "R5 restart at vector 0", 32'(vec_data_o[2]), 32'(vec_m(0)));
    endtask

    task automatic t_deadline();
        timeout_limit = 16'd5;
        wait_issue();
        repeat (4) @(negedge clk);
        respond(good_m(mi), good_m(mi), good_m(mi), 3'b111, 3'b000);
        mi = (mi + 1) % NV;
        chk(dut_rst_o == 3'b000, "R6 no reset at deadline", 32'(dut_rst_o), 0);
        chk_counts("R6 late good answer wins");
        wait_issue();
        repeat (4) @(negedge clk);
        respond(16'hBEEF, 16'hBEEF, 16'hBEEF, 3'b111, 3'b000);
        mi = (mi + 1) % NV; e1 = sat(e1 + 1);
        chk_counts("R6 late wrong answer is type 1 only");
    endtask

    task automatic t_disabled();
        timeout_limit = 16'd0;
        wait_issue();
        repeat (40) @(negedge clk);
        chk(vec_vld_o == 3'b111, "R7 no timeout when 0", 32'(vec_vld_o), 32'h7);
        chk_counts("R7 nothing counted");
        respond(good_m(mi), good_m(mi), good_m(mi), 3'b111, 3'b000);
        mi = (mi + 1) % NV;
        timeout_limit = 16'd100;
    endtask

    task automatic t_saturate();
        for (int n = 0; n < int'(CMAX) + 3; n++) begin
            wait_issue();
            respond(~good_m(mi), ~good_m(mi), ~good_m(mi), 3'b111, 3'b000);
            mi = (mi + 1) % NV; e1 = sat(e1 + 1);
        end
        chk(err_result_cnt == CMAX, "R10 saturated", 32'(err_result_cnt), 32'(CMAX));
        chk_counts("R10 counters after saturation");
    endtask

    task automatic t_clear();
        wait_issue();
        clr_counts = 1'b1;
        respond(~good_m(mi), ~good_m(mi), ~good_m(mi), 3'b111, 3'b000);
        clr_counts = 1'b0;
        mi = (mi + 1) % NV; e1 = 0; e2 = 0; e3 = 0;
        chk_counts("R11 clear wins over increment");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_good_run();
        t_minority();
        t_wrong();
        t_exception();
        t_timeout();
        t_deadline();
        t_disabled();
        t_saturate();
        t_clear();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule